// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit executes the shift family of a 64-bit RISC core, covering both the 32-bit word forms and the 64-bit doubleword forms. Each operation is one of three classes: logical left, arithmetic right or logical right. Three further inputs qualify it: a word-size select, a select between an immediate amount and a register amount, and a "plus 32" select for the upper-half immediate doubleword forms. The unit also receives the raw instruction word, the source operand and the amount register.

Logical right shift and rotate right share one operation class. A 5-bit selector field in the instruction word tells them apart. The field sits in a different place for immediate forms and for register forms. A selector value other than 0 or 1, or an unused class code, raises a reserved-instruction trap instead of producing a result.

The unit accepts work on a valid/ready input and presents it on a valid/ready output one clock later.

Input side:
- An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output stage is empty, or when its content is being taken in the same cycle (`out_ready` high).

Output side:
- A result is shown by `out_valid`. A trap is shown by `out_trap`. The two are never high together.
- Either flag, together with `out_result`, is held unchanged until `out_ready` is high.

Top module: `shift_rot_unit`

## Requirements
- R1: Class code 0 is a logical left shift. In the 32-bit form it shifts the low 32 bits of the source and sign-extends bit 31 of the 32-bit result to 64 bits. In the 64-bit form it shifts all 64 bits. Vacated positions are filled with zeros.
- R2: Class code 1 is an arithmetic right shift. The 32-bit form fills vacated positions with bit 31 of the source and sign-extends the result. The 64-bit form fills with bit 63.
- R3: Class code 2 with selector 0 is a logical right shift that fills with zeros. The 32-bit result is sign-extended from bit 31.
- R4: Class code 2 with selector 1 is a rotate right of the 32-bit or 64-bit word. A zero amount returns the word unchanged, so the 32-bit form returns the sign-extended low half.
- R5: The selector is instruction bits 25:21 in immediate forms and bits 10:6 in register forms. Class 2 with a selector of 2 to 31 raises `out_trap` with `out_valid` low. Classes 0 and 1 never trap, whatever the selector bits hold.
- R6: An immediate amount is instruction bits 10:6. In the 64-bit immediate form with `in_plus32` high, the amount is 32 plus that field. `in_plus32` has no effect on 32-bit forms or on register forms.
- R7: A register amount is `in_amt_reg[4:0]` for 32-bit forms and `in_amt_reg[5:0]` for 64-bit forms. All higher bits are ignored.
- R8: Class code 3 is reserved and always raises `out_trap` with `out_valid` low.
- R9: An operation accepted at a clock edge shows its flag and result right after that edge. A synchronous active-high reset clears `out_valid` and `out_trap`.
- R10: While an output is held with `out_ready` low, `in_ready` is low and `out_result` and the flags stay stable. An input offered in that time is not taken. It is accepted on the edge where `out_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 2 | Class: 0 left, 1 arithmetic right, 2 logical right/rotate, 3 reserved |
| in_dword | input | 1 | 1 = 64-bit form, 0 = 32-bit form |
| in_by_reg | input | 1 | 1 = amount from register, 0 = amount from instruction |
| in_plus32 | input | 1 | Adds 32 to an immediate amount in 64-bit forms |
| in_instr | input | 32 | Raw instruction word |
| in_src | input | 64 | Operand to shift |
| in_amt_reg | input | 64 | Register holding a variable amount |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_valid | output | 1 | Result present |
| out_trap | output | 1 | Reserved-instruction trap present |
| out_result | output | 64 | Shift or rotate result |

## Verification
The bench targets a zero-amount rotate. A design that treats it like a shift-by-width would return zero instead of the operand. It also covers negative 32-bit words under the arithmetic right shift, where a design filling from bit 63 or forgetting the sign extension gives the wrong upper bits.

Selector values 2 and 31 are tried in both field positions. A design decoding only the low selector bit would return a rotate where it should trap. A design reading the field from the wrong position would mix the amount and the selector.

Register amounts are given junk in the higher bits, and `in_plus32` is driven on forms where it must be ignored. These catch amount masks that are too wide.

A stall test checks that a held result does not change and that an input offered during the stall is not swallowed.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [1:0] {
    K_SLL = 2'd0,
    K_SRA = 2'd1,
    K_SRL = 2'd2,
    K_RSV = 2'd3
  } op_class_t;

  typedef enum logic [1:0] {
    M_SLL = 2'd0,
    M_SRA = 2'd1,
    M_SRL = 2'd2,
    M_ROR = 2'd3
  } shift_mode_t;

  localparam int INSTR_W    = 32;
  localparam int FIELD_W    = 5;
  localparam int IMM_SEL_LO = 21;
  localparam int REG_SEL_LO = 6;
  localparam int SHAMT_LO   = 6;
endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
  import shrot_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]               op,
  input  logic                     dword,
  input  logic                     by_reg,
  input  logic                     plus32,
  input  logic [INSTR_W-1:0]       instr,
  input  logic [XLEN-1:0]          amt_reg,
  output shift_mode_t              mode,
  output logic [$clog2(XLEN)-1:0]  amt,
  output logic                     trap
);
  localparam int AW = $clog2(XLEN);

  logic [FIELD_W-1:0] sel;
  logic [FIELD_W-1:0] shamt;

  assign sel   = by_reg ? instr[REG_SEL_LO +: FIELD_W] : instr[IMM_SEL_LO +: FIELD_W];
  assign shamt = instr[SHAMT_LO +: FIELD_W];

  always_comb begin
    if (by_reg) begin
      if (dword) amt = amt_reg[AW-1:0];
      else       amt = {1'b0, amt_reg[AW-2:0]};
    end else begin
      amt = {dword & plus32, shamt};
    end
  end

  always_comb begin
    mode = M_SLL;
    trap = 1'b0;
    case (op_class_t'(op))
      K_SLL: mode = M_SLL;
      K_SRA: mode = M_SRA;
      K_SRL: begin
        if (sel == FIELD_W'(0))      mode = M_SRL;
        else if (sel == FIELD_W'(1)) mode = M_ROR;
        else                         trap = 1'b1;
      end
      default: trap = 1'b1;
    endcase
  end
endmodule

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0]         a,
  input  logic [$clog2(W)-1:0] amt,
  input  shift_mode_t          mode,
  output logic [W-1:0]         y
);
  localparam int AW = $clog2(W);

  logic [AW:0] back;
  assign back = (AW+1)'(W) - {1'b0, amt};

  always_comb begin
    case (mode)
      M_SLL:   y = a << amt;
      M_SRA:   y = W'($signed(a) >>> amt);
      M_SRL:   y = a >> amt;
      default: y = (amt == '0) ? a : ((a >> amt) | (a << back));
    endcase
  end

  // R4: rotating the result left again by the same amount recovers the operand
  always_comb begin
    if (mode == M_ROR && amt != '0) begin
      assert_rot_inverse_R4: assert (((y << amt) | (y >> back)) == a);
    end
  end
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import shrot_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic              in_dword,
  input  logic              in_by_reg,
  input  logic              in_plus32,
  input  logic [31:0]       in_instr,
  input  logic [XLEN-1:0]   in_src,
  input  logic [XLEN-1:0]   in_amt_reg,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_trap,
  output logic [XLEN-1:0]   out_result
);
  localparam int HALF = XLEN / 2;
  localparam int AW   = $clog2(XLEN);
  localparam int HAW  = $clog2(HALF);

  shift_mode_t     mode;
  logic [AW-1:0]   amt;
  logic            trap;
  logic [XLEN-1:0] y_full;
  logic [HALF-1:0] y_half;
  logic [XLEN-1:0] result;

  shrot_decode #(.XLEN(XLEN)) u_decode (
    .op      (in_op),
    .dword   (in_dword),
    .by_reg  (in_by_reg),
    .plus32  (in_plus32),
    .instr   (in_instr),
    .amt_reg (in_amt_reg),
    .mode    (mode),
    .amt     (amt),
    .trap    (trap)
  );

  shrot_core #(.W(XLEN)) u_core_full (
    .a    (in_src),
    .amt  (amt),
    .mode (mode),
    .y    (y_full)
  );

  shrot_core #(.W(HALF)) u_core_half (
    .a    (in_src[HALF-1:0]),
    .amt  (amt[HAW-1:0]),
    .mode (mode),
    .y    (y_half)
  );

  assign result   = in_dword ? y_full : {{HALF{y_half[HALF-1]}}, y_half};
  assign in_ready = !(out_valid || out_trap) || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_trap   <= 1'b0;
      out_result <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid && !trap;
      out_trap  <= in_valid && trap;
      if (in_valid) out_result <= trap ? '0 : result;
    end
  end

  // R5/R8: a result and a trap are never presented together
  assert_no_dual_flag_R5: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_trap));

  // R5: left and arithmetic-right classes never trap
  assert_shift_no_trap_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_op == 2'd0 || in_op == 2'd1)) |=> (out_valid && !out_trap));

  // R9: an accepted operation produces a flag on the next cycle
  assert_accept_latency_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid || out_trap));

  // R10: a stalled output holds its flag and data
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  // R10: no intake while stalled
  assert_stall_no_ready_R10: assert property (@(posedge clk) disable iff (rst)
    ((out_valid || out_trap) && !out_ready) |-> !in_ready);
endmodule

// File: tb/test_shift_rot_unit.sv
module test_shift_rot_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = '0;
  logic        in_dword = 1'b0;
  logic        in_by_reg = 1'b0;
  logic        in_plus32 = 1'b0;
  logic [31:0] in_instr = '0;
  logic [63:0] in_src = '0;
  logic [63:0] in_amt_reg = '0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic        out_trap;
  logic [63:0] out_result;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  shift_rot_unit i_shift_rot_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dword(in_dword), .in_by_reg(in_by_reg),
    .in_plus32(in_plus32), .in_instr(in_instr), .in_src(in_src),
    .in_amt_reg(in_amt_reg), .out_ready(out_ready), .out_valid(out_valid),
    .out_trap(out_trap), .out_result(out_result)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [1:0] op, input bit w64, input bit ureg, input bit p32,
                                input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                                output bit trap, output logic [63:0] r);
    int n;
    int sel;
    logic [31:0] lo;
    logic [31:0] r32;
    sel = ureg ? int'(ins[10:6]) : int'(ins[25:21]);
    if (ureg) n = w64 ? int'(b[5:0]) : int'(b[4:0]);
    else      n = int'(ins[10:6]) + ((w64 && p32) ? 32 : 0);
    trap = (op == 2'd3) || (op == 2'd2 && sel > 1);
    r = '0;
    if (w64) begin
      case (op)
        2'd0: r = a << n;
        2'd1: r = $signed(a) >>> n;
        default: r = (sel == 1) ? ((n == 0) ? a : ((a >> n) | (a << (64 - n)))) : (a >> n);
      endcase
    end else begin
      lo = a[31:0];
      case (op)
        2'd0: r32 = lo << n;
        2'd1: r32 = $signed(lo) >>> n;
        default: r32 = (sel == 1) ? ((n == 0) ? lo : ((lo >> n) | (lo << (32 - n)))) : (lo >> n);
      endcase
      r = {{32{r32[31]}}, r32};
    end
  endfunction

  task automatic run(input logic [1:0] op, input bit w64, input bit ureg, input bit p32,
                     input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b, input string tag);
    bit tr;
    logic [63:0] ex;
    model(op, w64, ureg, p32, ins, a, b, tr, ex);
    @(negedge clk);
    in_op = op; in_dword = w64; in_by_reg = ureg; in_plus32 = p32;
    in_instr = ins; in_src = a; in_amt_reg = b; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_trap == tr, {tag, " trap flag R9"}, {63'd0, out_trap}, {63'd0, tr});
    chk(out_valid == !tr, {tag, " valid flag R9"}, {63'd0, out_valid}, {63'd0, !tr});
    if (!tr) chk(out_result == ex, tag, out_result, ex);
  endtask

  function automatic logic [31:0] imm_ins(input int sel, input int sh);
    return {11'd0, 5'(sel), 10'd0, 5'(sh), 6'd0};
  endfunction

  function automatic logic [31:0] reg_ins(input int sel);
    return {21'd0, 5'(sel), 6'd0};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit tr;
    logic [63:0] exA;
    logic [63:0] exB;
    void'($urandom(32'd20070405));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !out_trap, "R9 reset flags", {62'd0, out_valid, out_trap}, 64'd0);
    chk(in_ready == 1'b1, "R9 ready after reset", {63'd0, in_ready}, 64'd1);
    rst = 1'b0;

    // R4 zero-amount rotate, both widths
    run(2'd2, 1'b1, 1'b0, 1'b0, imm_ins(1, 0), 64'hF00D_1234_8765_4321, 64'd0, "R4 rotate64 by 0");
    run(2'd2, 1'b0, 1'b0, 1'b0, imm_ins(1, 0), 64'h1111_2222_8765_4321, 64'd0, "R4 rotate32 by 0");
    run(2'd2, 1'b0, 1'b1, 1'b0, reg_ins(1), 64'h0000_0000_8000_0001, 64'd0, "R4 rotatev32 by 0");
    run(2'd2, 1'b0, 1'b0, 1'b0, imm_ins(1, 4), 64'h0000_0000_0000_00F1, 64'd0, "R4 rotate32 by 4");
    // R2 negative 32-bit word
    run(2'd1, 1'b0, 1'b0, 1'b0, imm_ins(0, 8), 64'h0000_0000_8000_0000, 64'd0, "R2 sra32 negative");
    run(2'd1, 1'b1, 1'b0, 1'b0, imm_ins(0, 3), 64'h8000_0000_0000_0000, 64'd0, "R2 sra64 negative");
    // R1 left shift into bit 31
    run(2'd0, 1'b0, 1'b0, 1'b0, imm_ins(0, 31), 64'hFFFF_FFFF_0000_0001, 64'd0, "R1 sll32 sign");
    // R3 logical right
    run(2'd2, 1'b0, 1'b0, 1'b0, imm_ins(0, 1), 64'h0000_0000_8000_0000, 64'd0, "R3 srl32 zero fill");
    // R6 plus-32 forms
    run(2'd2, 1'b1, 1'b0, 1'b1, imm_ins(1, 4), 64'h0123_4567_89AB_CDEF, 64'd0, "R6 rotate64 plus32");
    run(2'd0, 1'b1, 1'b0, 1'b1, imm_ins(0, 0), 64'h0000_0000_DEAD_BEEF, 64'd0, "R6 sll64 plus32 by 0");
    run(2'd0, 1'b0, 1'b0, 1'b1, imm_ins(0, 2), 64'h0000_0000_0000_0003, 64'd0, "R6 plus32 ignored 32-bit");
    run(2'd2, 1'b1, 1'b1, 1'b1, reg_ins(0), 64'hFFFF_0000_FFFF_0000, 64'h0000_0000_0000_0004, "R6 plus32 ignored reg");
    // R7 upper amount bits ignored
    run(2'd0, 1'b0, 1'b1, 1'b0, reg_ins(0), 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFE3, "R7 reg amount 32 mask");
    run(2'd2, 1'b1, 1'b1, 1'b0, reg_ins(1), 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFC1, "R7 reg amount 64 mask");
    // R5 selector traps in both positions, R8 reserved class
    run(2'd2, 1'b0, 1'b0, 1'b0, imm_ins(2, 3), 64'h1, 64'd0, "R5 imm selector 2");
    run(2'd2, 1'b1, 1'b1, 1'b0, reg_ins(31), 64'h1, 64'd1, "R5 reg selector 31");
    run(2'd2, 1'b0, 1'b1, 1'b0, {6'd0, 5'd3, 15'd0, 6'd0}, 64'h5, 64'd1, "R5 reg form ignores imm field");
    run(2'd0, 1'b1, 1'b0, 1'b0, imm_ins(9, 3), 64'h5, 64'd0, "R5 sll ignores selector");
    run(2'd3, 1'b1, 1'b0, 1'b0, imm_ins(0, 3), 64'h5, 64'd0, "R8 reserved class");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      bit w, u, p;
      logic [31:0] ins;
      op = 2'($urandom % 4);
      if (op == 2'd3 && ($urandom % 4) != 0) op = 2'd2;
      w = 1'($urandom); u = 1'($urandom); p = 1'($urandom);
      ins = $urandom;
      if (u) ins[10:6] = 5'($urandom % 3);
      else   ins[25:21] = 5'($urandom % 3);
      run(op, w, u, p, ins, {$urandom, $urandom}, {$urandom, $urandom}, "R1/R2/R3/R4 random");
    end

    // R10 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    model(2'd1, 1'b1, 1'b0, 1'b0, imm_ins(0, 5), 64'h8000_1234_0000_0000, 64'd0, tr, exA);
    in_op = 2'd1; in_dword = 1'b1; in_by_reg = 1'b0; in_plus32 = 1'b0;
    in_instr = imm_ins(0, 5); in_src = 64'h8000_1234_0000_0000; in_valid = 1'b1;
    @(negedge clk);
    model(2'd0, 1'b1, 1'b0, 1'b0, imm_ins(0, 8), 64'h0000_0000_0000_00AB, 64'd0, tr, exB);
    in_op = 2'd0; in_instr = imm_ins(0, 8); in_src = 64'h0000_0000_0000_00AB;
    chk(in_ready == 1'b0, "R10 ready low when stalled", {63'd0, in_ready}, 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid && out_result == exA, "R10 held result", out_result, exA);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_result == exB, "R10 offered input taken after stall", out_result, exB);
    @(negedge clk);
    chk(!out_valid && !out_trap, "R10 output drained", {62'd0, out_valid, out_trap}, 64'd0);

    // R9 mid-run reset clears a held trap
    out_ready = 1'b0;
    run(2'd3, 1'b0, 1'b0, 1'b0, 32'd0, 64'd0, 64'd0, "R8 trap before reset");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    out_ready = 1'b1;
    chk(!out_valid && !out_trap, "R9 reset clears held flags", {62'd0, out_valid, out_trap}, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule